// File: doc/BRIEF.md
# Slot-Based Priority Interrupt Arbiter

This block sits between a set of peripheral interrupt lines and a processor core. Every source starts at the lowest urgency, level 0. Software can lift a few chosen sources to level 1 or level 2 by writing their vector numbers into assignment slots. There are three slots for each of the two raised levels. On each cycle the block finds, within every level, the pending source with the smallest vector number. It then takes the most urgent level that clears the core's current mask level.

The winner is registered and presented to the core as a request. The request carries the vector number and a service address, which is formed from a programmable base plus two words per vector. A separate flag marks the top vector as a fast interrupt when that option is enabled. A presented request stays frozen while its source keeps requesting, until the core acknowledges it. Slot contents, the base and the fast option are set through a small synchronous register port and can be read back.

Top module: `slot_irq_arbiter`

## Requirements
- R1: After reset, int_req and int_fast are 0, all slots are invalid, the vector base is 0, the fast option is off, and every register address reads 0.
- R2: Register addresses 0, 1 and 2 are the level-1 slots, and 3, 4 and 5 are the level-2 slots. A slot word carries the valid bit at bit 6 and the vector number in bits 5:0. Address 6 holds the 16-bit vector base, and bit 0 of address 7 is the fast option. Reading an address returns the value written to it, with unused bits reading 0.
- R3: A source named in no valid slot is at level 0.
- R4: Level 2 beats level 1, and level 1 beats level 0. A vector that appears in a valid slot of each raised level counts as level 2.
- R5: Among pending sources of the same level, the smallest vector number wins.
- R6: A source is presented only if its level is greater than or equal to core_mask. When core_mask is 3, no new request is raised.
- R7: int_addr equals the vector base plus twice int_vec, modulo 2^16.
- R8: int_fast is 1 only when the presented vector is 50 and the fast option is on.
- R9: When the outputs are not frozen, they show the winner of the request lines and settings sampled at the previous clock edge. With no line pending, int_req is 0.
- R10: While int_req is 1, int_ack is 0 and the line of the presented vector stays high, the outputs hold their values even if a more urgent source arrives. int_ack forces int_req to 0 on the next cycle. When the presented line drops, the block re-arbitrates at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | NUM_SRC (51) | Peripheral request lines, bit n is vector n |
| core_mask | input | 2 | Core's current interrupt mask level |
| int_ack | input | 1 | Core accepts the presented interrupt |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RADDR_W (3) | Register address |
| reg_wdata | input | DATA_W (16) | Register write data |
| reg_rdata | output | DATA_W (16) | Register read data for reg_addr |
| int_req | output | 1 | Interrupt request to the core |
| int_vec | output | VEC_W (6) | Presented vector number |
| int_addr | output | ADDR_W (16) | Service address of the presented vector |
| int_fast | output | 1 | Presented vector is flagged fast |

## Verification
Two events can meet in the same cycle. A more urgent source may arrive while an earlier winner is still frozen, and an acknowledge or a drop of the frozen line may come at that moment. The bench provokes this directly. It holds a level-1 winner, raises a level-2 source alongside it, and then either acknowledges or drops the held line. The held outputs must stay unchanged until that release. After it comes one idle cycle following an acknowledge, or an immediate switch following a drop. Randomised patterns of slots, masks and bases are compared cycle by cycle against a bench model of the level and encoding rules.

// File: rtl/slot_irq_pkg.sv
package slot_irq_pkg;
   typedef logic [1:0] lvl_t;
   localparam lvl_t LVL_BASE = 2'd0;
   localparam lvl_t LVL_MID  = 2'd1;
   localparam lvl_t LVL_TOP  = 2'd2;
   localparam int unsigned NUM_LEVELS = 3;
endpackage

// File: rtl/slot_irq_regs.sv
module slot_irq_regs #(
   parameter int unsigned SLOTS   = 3,
   parameter int unsigned VEC_W   = 6,
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned RADDR_W = 3
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             we,
   input  logic [RADDR_W-1:0]               addr,
   input  logic [DATA_W-1:0]                wdata,
   output logic [DATA_W-1:0]                rdata,
   output logic [2*SLOTS-1:0]               slot_vld,
   output logic [2*SLOTS-1:0][VEC_W-1:0]    slot_vec,
   output logic [ADDR_W-1:0]                vbase,
   output logic                             fast_en
);
   localparam int unsigned NSLOT     = 2 * SLOTS;
   localparam int unsigned BASE_IDX  = NSLOT;
   localparam int unsigned FAST_IDX  = NSLOT + 1;

   generate
      if (DATA_W < VEC_W + 1) begin : g_bad_slot_width
         $error("slot word does not fit data width");
      end
      if (DATA_W < ADDR_W) begin : g_bad_base_width
         $error("vector base does not fit data width");
      end
      if ((1 << RADDR_W) < FAST_IDX + 1) begin : g_bad_raddr
         $error("register address too narrow");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < NSLOT; gi++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot_vld[gi] <= 1'b0;
               slot_vec[gi] <= '0;
            end else if (we && addr == RADDR_W'(gi)) begin
               slot_vld[gi] <= wdata[VEC_W];
               slot_vec[gi] <= wdata[VEC_W-1:0];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vbase   <= '0;
         fast_en <= 1'b0;
      end else if (we) begin
         if (addr == RADDR_W'(BASE_IDX)) vbase   <= wdata[ADDR_W-1:0];
         if (addr == RADDR_W'(FAST_IDX)) fast_en <= wdata[0];
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NSLOT; i++) begin
         if (addr == RADDR_W'(i)) rdata[VEC_W:0] = {slot_vld[i], slot_vec[i]};
      end
      if (addr == RADDR_W'(BASE_IDX)) rdata[ADDR_W-1:0] = vbase;
      if (addr == RADDR_W'(FAST_IDX)) rdata[0] = fast_en;
   end
endmodule

// File: rtl/slot_irq_level_map.sv
module slot_irq_level_map
   import slot_irq_pkg::*;
#(
   parameter int unsigned NUM_SRC = 51,
   parameter int unsigned SLOTS   = 3,
   parameter int unsigned VEC_W   = 6
) (
   input  logic [2*SLOTS-1:0]            slot_vld,
   input  logic [2*SLOTS-1:0][VEC_W-1:0] slot_vec,
   output lvl_t [NUM_SRC-1:0]            src_lvl
);
   genvar gs;
   generate
      for (gs = 0; gs < NUM_SRC; gs++) begin : g_src
         logic hit_mid, hit_top;
         always_comb begin
            hit_mid = 1'b0;
            hit_top = 1'b0;
            for (int k = 0; k < int'(SLOTS); k++) begin
               if (slot_vld[k] && slot_vec[k] == VEC_W'(gs))
                  hit_mid = 1'b1;
               if (slot_vld[SLOTS+k] && slot_vec[SLOTS+k] == VEC_W'(gs))
                  hit_top = 1'b1;
            end
            if (hit_top)      src_lvl[gs] = LVL_TOP;
            else if (hit_mid) src_lvl[gs] = LVL_MID;
            else              src_lvl[gs] = LVL_BASE;
         end
      end
   endgenerate
endmodule

// File: rtl/slot_irq_level_enc.sv
module slot_irq_level_enc
   import slot_irq_pkg::*;
#(
   parameter int unsigned NUM_SRC = 51,
   parameter int unsigned VEC_W   = 6,
   parameter lvl_t        LEVEL   = LVL_BASE
) (
   input  logic [NUM_SRC-1:0] irq_req,
   input  lvl_t [NUM_SRC-1:0] src_lvl,
   output logic               any,
   output logic [VEC_W-1:0]   vec
);
   logic [NUM_SRC-1:0] act;

   always_comb begin
      for (int s = 0; s < int'(NUM_SRC); s++)
         act[s] = irq_req[s] && (src_lvl[s] == LEVEL);
   end

   always_comb begin
      vec = '0;
      for (int s = int'(NUM_SRC) - 1; s >= 0; s--) begin
         if (act[s]) vec = VEC_W'(s);
      end
   end

   assign any = |act;
endmodule

// File: rtl/slot_irq_arbiter.sv
module slot_irq_arbiter
   import slot_irq_pkg::*;
#(
   parameter int unsigned NUM_SRC = 51,
   parameter int unsigned VEC_W   = 6,
   parameter int unsigned SLOTS   = 3,
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned RADDR_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SRC-1:0]   irq_req,
   input  logic [1:0]           core_mask,
   input  logic                 int_ack,
   input  logic                 reg_we,
   input  logic [RADDR_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]    reg_wdata,
   output logic [DATA_W-1:0]    reg_rdata,
   output logic                 int_req,
   output logic [VEC_W-1:0]     int_vec,
   output logic [ADDR_W-1:0]    int_addr,
   output logic                 int_fast
);
   localparam int unsigned VEC_SPAN = 1 << VEC_W;
   localparam logic [VEC_W-1:0] FAST_VEC = VEC_W'(NUM_SRC - 1);

   generate
      if (NUM_SRC > VEC_SPAN) begin : g_bad_src
         $error("NUM_SRC exceeds vector space");
      end
      if (ADDR_W <= VEC_W) begin : g_bad_addr
         $error("ADDR_W must exceed VEC_W");
      end
      if (SLOTS == 0) begin : g_bad_slots
         $error("SLOTS must be nonzero");
      end
   endgenerate

   logic [2*SLOTS-1:0]            slot_vld;
   logic [2*SLOTS-1:0][VEC_W-1:0] slot_vec;
   logic [ADDR_W-1:0]             vbase;
   logic                          fast_en;
   lvl_t [NUM_SRC-1:0]            src_lvl;
   logic [NUM_LEVELS-1:0]         lvl_any;
   logic [NUM_LEVELS-1:0][VEC_W-1:0] lvl_vec;

   slot_irq_regs #(
      .SLOTS(SLOTS), .VEC_W(VEC_W), .ADDR_W(ADDR_W),
      .DATA_W(DATA_W), .RADDR_W(RADDR_W)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .slot_vld(slot_vld),
      .slot_vec(slot_vec), .vbase(vbase), .fast_en(fast_en)
   );

   slot_irq_level_map #(
      .NUM_SRC(NUM_SRC), .SLOTS(SLOTS), .VEC_W(VEC_W)
   ) i_map (
      .slot_vld(slot_vld), .slot_vec(slot_vec), .src_lvl(src_lvl)
   );

   genvar gl;
   generate
      for (gl = 0; gl < NUM_LEVELS; gl++) begin : g_lvl
         slot_irq_level_enc #(
            .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .LEVEL(lvl_t'(gl))
         ) i_enc (
            .irq_req(irq_req), .src_lvl(src_lvl),
            .any(lvl_any[gl]), .vec(lvl_vec[gl])
         );
      end
   endgenerate

   logic             win_vld;
   logic [VEC_W-1:0] win_vec;
   logic [ADDR_W-1:0] win_addr;
   logic             win_fast;

   always_comb begin
      win_vld = 1'b0;
      win_vec = '0;
      for (int l = 0; l < int'(NUM_LEVELS); l++) begin
         if (lvl_any[l] && (2'(l) >= core_mask)) begin
            win_vld = 1'b1;
            win_vec = lvl_vec[l];
         end
      end
      win_addr = vbase + ADDR_W'({win_vec, 1'b0});
      win_fast = win_vld && fast_en && (win_vec == FAST_VEC);
   end

   logic [VEC_SPAN-1:0] req_pad;
   logic                hold;
   assign req_pad = VEC_SPAN'(irq_req);
   assign hold    = int_req && req_pad[int_vec];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_req  <= 1'b0;
         int_vec  <= '0;
         int_addr <= '0;
         int_fast <= 1'b0;
      end else if (int_ack) begin
         int_req  <= 1'b0;
         int_fast <= 1'b0;
      end else if (!hold) begin
         int_req  <= win_vld;
         int_vec  <= win_vec;
         int_addr <= win_addr;
         int_fast <= win_fast;
      end
   end
endmodule

// File: rtl/slot_irq_arbiter_chk.sv
module slot_irq_arbiter_chk #(
   parameter int unsigned NUM_SRC = 51,
   parameter int unsigned VEC_W   = 6,
   parameter int unsigned ADDR_W  = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] irq_req,
   input logic [1:0]         core_mask,
   input logic               int_ack,
   input logic               int_req,
   input logic [VEC_W-1:0]   int_vec,
   input logic [ADDR_W-1:0]  int_addr,
   input logic               int_fast
);
   localparam int unsigned SPAN = 1 << VEC_W;
   logic [SPAN-1:0] pad;
   assign pad = SPAN'(irq_req);

   // R10: acknowledge clears the request next cycle
   a_r10_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
      int_ack |=> !int_req);

   // R10: frozen outputs while the presented line stays high
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (int_req && !int_ack && pad[int_vec]) |=>
      (int_req && $stable(int_vec) && $stable(int_addr)));

   // R8: fast flag only with the top vector presented
   a_r8_fast_top: assert property (@(posedge clk) disable iff (!rst_n)
      int_fast |-> (int_req && int_vec == VEC_W'(NUM_SRC - 1)));

   // R6: mask level 3 raises nothing new
   a_r6_mask_top: assert property (@(posedge clk) disable iff (!rst_n)
      (core_mask == 2'd3 && !int_req) |=> !int_req);

   // R9: no pending line gives no request
   a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req == '0) |=> !int_req);
endmodule

bind slot_irq_arbiter slot_irq_arbiter_chk #(
   .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .ADDR_W(ADDR_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .core_mask(core_mask),
   .int_ack(int_ack), .int_req(int_req), .int_vec(int_vec),
   .int_addr(int_addr), .int_fast(int_fast)
);

// File: tb/test_slot_irq_arbiter.sv
module test_slot_irq_arbiter;
   localparam int NS = 51;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [NS-1:0] irq_req = '0;
   logic [1:0]  core_mask = 2'd0;
   logic        int_ack = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        int_req;
   logic [5:0]  int_vec;
   logic [15:0] int_addr;
   logic        int_fast;

   int total = 0;
   int bad = 0;
   bit done = 0;

   // bench model of the programmed state
   logic       m_v [6];
   logic [5:0] m_s [6];
   logic [15:0] m_base = '0;
   logic       m_fast = 1'b0;

   always #2 clk = ~clk;

   slot_irq_arbiter i_slot_irq_arbiter (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .core_mask(core_mask),
      .int_ack(int_ack), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .int_req(int_req),
      .int_vec(int_vec), .int_addr(int_addr), .int_fast(int_fast)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(int a, logic [15:0] d);
      reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
      tick();
      reg_we = 1'b0;
      if (a < 6) begin m_v[a] = d[6]; m_s[a] = d[5:0]; end
      else if (a == 6) m_base = d;
      else m_fast = d[0];
   endtask

   function automatic int mdl_lvl(int s);
      int l = 0;
      for (int i = 0; i < 3; i++) if (m_v[i] && int'(m_s[i]) == s) l = 1;
      for (int i = 3; i < 6; i++) if (m_v[i] && int'(m_s[i]) == s) l = 2;
      return l;
   endfunction

   function automatic int mdl_win(logic [NS-1:0] r, logic [1:0] m);
      int best = -1;
      int bl = -1;
      for (int s = 0; s < NS; s++) begin
         if (r[s]) begin
            int l = mdl_lvl(s);
            if (l >= int'(m) && l > bl) begin best = s; bl = l; end
         end
      end
      return best;
   endfunction

   task automatic chk_out(string tag);
      int w = mdl_win(irq_req, core_mask);
      chk({tag, " req"}, 32'(int_req), 32'(w >= 0));
      if (w >= 0) begin
         chk({tag, " vec"}, 32'(int_vec), 32'(w));
         chk({tag, " addr"}, 32'(int_addr), 32'(16'(m_base + 16'(2 * w))));
         chk({tag, " fast"}, 32'(int_fast), 32'(m_fast && w == NS - 1));
      end
   endtask

   initial begin
      #(4 * 150000);
      total++; bad++;
      $display("FAIL watchdog expired");
      if (!done) begin
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd5150));
      for (int i = 0; i < 6; i++) begin m_v[i] = 0; m_s[i] = 0; end
      #9 rst_n = 1'b1;
      tick();

      // R1 reset state and zero reads
      chk("R1 int_req", 32'(int_req), 0);
      chk("R1 int_fast", 32'(int_fast), 0);
      for (int a = 0; a < 8; a++) begin
         reg_addr = 3'(a); #1;
         chk("R1 read", 32'(reg_rdata), 0);
      end

      // R2 programming and readback
      wr(0, 16'h0068); wr(1, 16'h006D); wr(3, 16'hFF6D);
      wr(6, 16'h1F00);
      reg_addr = 3'd0; #1; chk("R2 slot0", 32'(reg_rdata), 32'h68);
      reg_addr = 3'd3; #1; chk("R2 slot3 unused bits", 32'(reg_rdata), 32'h6D);
      reg_addr = 3'd6; #1; chk("R2 base", 32'(reg_rdata), 32'h1F00);
      wr(7, 16'hFFFF);
      reg_addr = 3'd7; #1; chk("R2 fast", 32'(reg_rdata), 1);
      wr(7, 16'h0000);

      // R3 unassigned source at level 0
      irq_req = '0; irq_req[5] = 1'b1; tick();
      chk("R3 vec", 32'(int_vec), 5);
      chk("R9 req", 32'(int_req), 1);
      irq_req = '0; tick();
      core_mask = 2'd1; irq_req[5] = 1'b1; tick();
      chk("R6 level0 masked", 32'(int_req), 0);
      core_mask = 2'd0;

      // R5 lowest vector within level
      irq_req = '0; tick();
      irq_req[7] = 1; irq_req[3] = 1; irq_req[20] = 1; tick();
      chk("R5 lowest", 32'(int_vec), 3);

      // R4 level ordering, duplicate slot counts as level 2
      irq_req = '0; tick();
      irq_req[3] = 1; irq_req[40] = 1; irq_req[45] = 1; tick();
      chk("R4 level2 wins", 32'(int_vec), 45);
      chk("R7 addr", 32'(int_addr), 32'h1F5A);
      irq_req = '0; tick();
      irq_req[3] = 1; irq_req[40] = 1; tick();
      chk("R4 level1 over 0", 32'(int_vec), 40);

      // R6 mask
      irq_req = '0; tick();
      core_mask = 2'd2; irq_req[3] = 1; irq_req[40] = 1; tick();
      chk("R6 mask2 blocks", 32'(int_req), 0);
      core_mask = 2'd3; irq_req[45] = 1; tick();
      chk("R6 mask3 blocks", 32'(int_req), 0);
      core_mask = 2'd2; tick();
      chk("R6 mask2 passes l2", 32'(int_vec), 45);
      core_mask = 2'd0;

      // R7 wrap and R8 fast
      irq_req = '0; wr(6, 16'hFFF0); tick();
      irq_req[50] = 1; tick();
      chk("R7 wrap", 32'(int_addr), 32'h0054);
      chk("R8 fast off", 32'(int_fast), 0);
      irq_req = '0; wr(7, 16'h0001); tick();
      irq_req[50] = 1; tick();
      chk("R8 fast on", 32'(int_fast), 1);
      irq_req = '0; tick();
      irq_req[3] = 1; tick();
      chk("R8 not top", 32'(int_fast), 0);

      // R10 hold, ack, drop
      irq_req = '0; wr(6, 16'h0100); tick();
      irq_req[40] = 1; tick();
      chk("R10 first", 32'(int_vec), 40);
      irq_req[45] = 1; tick();
      chk("R10 held vec", 32'(int_vec), 40);
      chk("R10 held req", 32'(int_req), 1);
      int_ack = 1; tick();
      int_ack = 0;
      chk("R10 ack drops", 32'(int_req), 0);
      tick();
      chk("R10 rearb", 32'(int_vec), 45);
      irq_req[45] = 0; tick();
      chk("R10 drop switch", 32'(int_vec), 40);
      chk("R10 drop addr", 32'(int_addr), 32'h0150);

      // random patterns
      for (int it = 0; it < 400; it++) begin
         irq_req = '0; tick();
         chk("R9 idle", 32'(int_req), 0);
         if ($urandom_range(0, 3) == 0) begin
            wr($urandom_range(0, 5), 16'({1'($urandom_range(0, 1)), 6'($urandom_range(0, 50))}));
            tick();
         end
         if ($urandom_range(0, 9) == 0) begin wr(6, 16'($urandom())); tick(); end
         if ($urandom_range(0, 9) == 0) begin wr(7, 16'($urandom_range(0, 1))); tick(); end
         core_mask = 2'($urandom_range(0, 3));
         irq_req = NS'({$urandom(), $urandom()} & {$urandom(), $urandom()}
                       & {$urandom(), $urandom()});
         tick();
         chk_out("R4 R5 R6 R7 R8 R9 random");
         core_mask = 2'd0;
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule